// File: doc/BRIEF.md
# Full-Frame SPI Panel Pixel Streamer

This block drives a small serial display controller that keeps its own frame memory. It refreshes the whole screen as one continuous video stream. On every tick of an internal frame timer it lowers chip select and sends a column-window command and a row-window command. Each window command carries four parameter bytes that span the full screen. The block then sends the memory-write opcode. After that opcode it clocks out every RGB565 pixel of the frame in the same transaction, and releases chip select only once the last bit has gone out.

Pixels arrive on a ready/valid stream from an upstream source, such as a compositor reading planes from external memory. A slow source only stretches the frame. The serial clock parks low between bytes and picks up again with no pixel lost or repeated. The panel gives no sync output, so frames are free-running at a fixed rate. A timer tick that lands during a busy frame is remembered, and the next frame starts as soon as the current one finishes. Panel power-up, panel initialisation and read-back are left to other logic.

Top module: `spi_frame_streamer`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0 and pix_ready is 0 until the first frame starts. spi_sclk is never 1 while spi_cs_n is 1.
- R2: A frame starts on the clock after each frame-timer tick, and the timer fires every FRAME_CLKS cycles. When every frame finishes inside its period, consecutive falling edges of spi_cs_n are exactly FRAME_CLKS cycles apart.
- R3: Each frame is one chip-select-low transaction. Its bytes are, in order: 0x2A, 0x00, 0x00, high and low byte of H_PIXELS-1; 0x2B, 0x00, 0x00, high and low byte of V_PIXELS-1; 0x2C; then exactly 2*H_PIXELS*V_PIXELS pixel bytes. spi_cs_n rises after the last pixel byte.
- R4: spi_dc is 0 for the three opcode bytes (0x2A, 0x2B, 0x2C) and 1 for all parameter and pixel bytes. It holds steady through each byte and changes only while spi_cs_n is 0 and spi_sclk is 0.
- R5: Each 16-bit pixel is sent as bits [15:8] first, then bits [7:0], each byte MSB first. The bus runs in SPI mode 0: spi_sclk idles low, the panel samples on the rising edge, and spi_mosi changes only while spi_sclk is low.
- R6: Every high and every low phase of spi_sclk lasts at least HALF = ceil(CLK_HZ / (2*SCLK_MAX_HZ)) clock cycles. With 50 MHz and 20 MHz this is 2 cycles, so each high phase is exactly 2 cycles.
- R7: A pixel is taken only in a cycle with pix_valid and pix_ready both 1. pix_ready is 1 only while spi_cs_n is 0. Accepted pixels appear on the bus once each, in acceptance order, H_PIXELS*V_PIXELS per frame.
- R8: While pix_valid is 0 in the pixel phase, spi_sclk stays 0 at a byte boundary, and spi_cs_n and spi_dc hold. Streaming resumes when valid returns.
- R9: A tick during a frame is held pending. spi_cs_n then goes high for exactly one cycle before the next frame begins. Several ticks within one frame produce only one extra frame, so the frame after it waits for a fresh tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_data | input | 16 | RGB565 pixel from upstream |
| pix_valid | input | 1 | pix_data holds a pixel |
| pix_ready | output | 1 | Pixel accepted this cycle when valid |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Chip select, low for a whole frame |
| spi_dc | output | 1 | 0 = opcode byte, 1 = parameter or pixel byte |

## Verification
On every cycle, the assertions check the bus rules: the serial clock stays parked while deselected, the data/command line and the data line change only in safe windows, each clock phase meets its minimum width, and the pixel handshake stays inside a transaction. The frame content can only be shown by the bench scenarios. These cover the exact byte sequence and the pixel byte order under differing source stall patterns, the fixed spacing between frame starts, and the one-cycle deselect after an overrun frame. They also show that several ticks during an overrun collapse into one frame.

// File: rtl/spi_stream_pkg.sv
// Shared types for the full-frame SPI pixel streamer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package spi_stream_pkg;

    // Frame sequencer phases
    typedef enum logic [2:0] {
        SQ_IDLE,    // waiting for a frame tick, chip select high
        SQ_CMD,     // window and memory-write command bytes
        SQ_PIX_HI,  // upper byte of the current pixel
        SQ_PIX_LO,  // lower byte of the current pixel
        SQ_DRAIN    // last byte on the wire, then deselect
    } seq_state_t;

    // Number of bytes in the per-frame command header
    localparam int unsigned HDR_BYTES = 11;

endpackage

// File: rtl/frame_pacer.sv
// Free-running frame timer: pulses tick for one cycle every PERIOD cycles.
// Assumes: PERIOD >= 2; no external sync source exists.
module frame_pacer #(
    parameter int unsigned PERIOD = 1_666_666
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = $clog2(PERIOD);

    logic [CW-1:0] cnt;

    // Count cycles within a frame period and wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(PERIOD - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(PERIOD - 1));

endmodule

// File: rtl/byte_serializer.sv
// Mode-0 byte shifter: loads one byte plus its D/C flag and shifts it out
// MSB first, each SCLK phase lasting HALF clocks. SCLK rests low when idle.
// Assumes: load is only raised while ready is high.
module byte_serializer #(
    parameter int unsigned HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] ld_data,
    input  logic       ld_dc,
    output logic       ready,
    output logic       sclk,
    output logic       mosi,
    output logic       dc
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic          busy;
    logic [7:0]    shreg;
    logic [2:0]    bitn;
    logic [CW-1:0] phase_cnt;

    // Load, time the clock phases and shift on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            shreg     <= '0;
            bitn      <= '0;
            phase_cnt <= '0;
            sclk      <= 1'b0;
            dc        <= 1'b1;
        end else if (load && !busy) begin
            busy      <= 1'b1;
            shreg     <= ld_data;
            bitn      <= '0;
            phase_cnt <= '0;
            sclk      <= 1'b0;
            dc        <= ld_dc;
        end else if (busy) begin
            if (phase_cnt == CW'(HALF - 1)) begin
                phase_cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7)
                        busy <= 1'b0;
                    else begin
                        bitn  <= bitn + 1'b1;
                        shreg <= {shreg[6:0], 1'b0};
                    end
                end
            end else begin
                phase_cnt <= phase_cnt + 1'b1;
            end
        end
    end

    assign ready = !busy;
    assign mosi  = shreg[7];

endmodule

// File: rtl/frame_sequencer.sv
// Frame sequencer: on a tick (or a pending one) lowers chip select, issues
// the full-screen window header and memory-write opcode, then feeds
// H_PIXELS*V_PIXELS pixels high byte first, and deselects after the last bit.
// Assumes: the serializer accepts a byte only when its ready is high.
module frame_sequencer
    import spi_stream_pkg::*;
#(
    parameter int unsigned H_PIXELS = 160,
    parameter int unsigned V_PIXELS = 128,
    parameter logic [7:0]  OP_COLS  = 8'h2A,
    parameter logic [7:0]  OP_ROWS  = 8'h2B,
    parameter logic [7:0]  OP_WRITE = 8'h2C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        ser_ready,
    input  logic [15:0] pix_data,
    input  logic        pix_valid,
    output logic        pix_ready,
    output logic        ser_load,
    output logic [7:0]  ser_data,
    output logic        ser_dc,
    output logic        cs_n
);
    localparam int unsigned NPIX    = H_PIXELS * V_PIXELS;
    localparam int unsigned PW      = (NPIX > 2) ? $clog2(NPIX) : 1;
    localparam logic [15:0] COL_END = 16'(H_PIXELS - 1);
    localparam logic [15:0] ROW_END = 16'(V_PIXELS - 1);

    seq_state_t    state;
    logic [3:0]    hdr_idx;
    logic [PW-1:0] pix_cnt;
    logic [7:0]    lo_q;
    logic          pend;
    logic          start;
    logic          offer;

    // Header byte by position; the order is what the panel decodes
    function automatic logic [7:0] hdr_byte(input logic [3:0] i);
        case (i)
            4'd0:    hdr_byte = OP_COLS;
            4'd3:    hdr_byte = COL_END[15:8];
            4'd4:    hdr_byte = COL_END[7:0];
            4'd5:    hdr_byte = OP_ROWS;
            4'd8:    hdr_byte = ROW_END[15:8];
            4'd9:    hdr_byte = ROW_END[7:0];
            4'd10:   hdr_byte = OP_WRITE;
            default: hdr_byte = 8'h00;
        endcase
    endfunction

    // Opcode positions carry D/C low, all others high
    function automatic logic hdr_dc(input logic [3:0] i);
        hdr_dc = !(i == 4'd0 || i == 4'd5 || i == 4'd10);
    endfunction

    assign start = (state == SQ_IDLE) && (tick || pend);

    // Select the byte offered to the serializer in each phase
    always_comb begin
        offer    = 1'b0;
        ser_data = 8'h00;
        ser_dc   = 1'b1;
        case (state)
            SQ_CMD: begin
                offer    = 1'b1;
                ser_data = hdr_byte(hdr_idx);
                ser_dc   = hdr_dc(hdr_idx);
            end
            SQ_PIX_HI: begin
                offer    = pix_valid;
                ser_data = pix_data[15:8];
            end
            SQ_PIX_LO: begin
                offer    = 1'b1;
                ser_data = lo_q;
            end
            default: ;
        endcase
    end

    assign ser_load  = offer && ser_ready;
    assign pix_ready = (state == SQ_PIX_HI) && ser_ready;

    // Remember a tick that arrives while a frame is running
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (start)
            pend <= 1'b0;
        else if (tick)
            pend <= 1'b1;
    end

    // Advance through header, pixels and drain; drive chip select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            hdr_idx <= '0;
            pix_cnt <= '0;
            lo_q    <= '0;
            cs_n    <= 1'b1;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    cs_n    <= 1'b0;
                    hdr_idx <= '0;
                    state   <= SQ_CMD;
                end
                SQ_CMD: if (ser_load) begin
                    if (hdr_idx == 4'(HDR_BYTES - 1)) begin
                        pix_cnt <= '0;
                        state   <= SQ_PIX_HI;
                    end else begin
                        hdr_idx <= hdr_idx + 1'b1;
                    end
                end
                SQ_PIX_HI: if (ser_load) begin
                    lo_q  <= pix_data[7:0];
                    state <= SQ_PIX_LO;
                end
                SQ_PIX_LO: if (ser_load) begin
                    if (pix_cnt == PW'(NPIX - 1))
                        state <= SQ_DRAIN;
                    else begin
                        pix_cnt <= pix_cnt + 1'b1;
                        state   <= SQ_PIX_HI;
                    end
                end
                SQ_DRAIN: if (ser_ready) begin
                    cs_n  <= 1'b1;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_frame_streamer.sv
// Top level: frame timer, frame sequencer and mode-0 byte shifter.
// Assumes: CLK_HZ and SCLK_MAX_HZ set the SCLK half period; FRAME_CLKS
// sets the frame rate and defaults to CLK_HZ / FPS.
module spi_frame_streamer #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned SCLK_MAX_HZ = 20_000_000,
    parameter int unsigned FPS         = 30,
    parameter int unsigned FRAME_CLKS  = CLK_HZ / FPS,
    parameter int unsigned H_PIXELS    = 160,
    parameter int unsigned V_PIXELS    = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] pix_data,
    input  logic        pix_valid,
    output logic        pix_ready,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    output logic        spi_dc
);
    localparam int unsigned HALF =
        (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);

    logic       tick;
    logic       ser_ready;
    logic       ser_load;
    logic [7:0] ser_data;
    logic       ser_dc;

    frame_pacer #(.PERIOD(FRAME_CLKS)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    frame_sequencer #(
        .H_PIXELS (H_PIXELS),
        .V_PIXELS (V_PIXELS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ser_ready (ser_ready),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .ser_load  (ser_load),
        .ser_data  (ser_data),
        .ser_dc    (ser_dc),
        .cs_n      (spi_cs_n)
    );

    byte_serializer #(.HALF(HALF)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ser_load),
        .ld_data (ser_data),
        .ld_dc   (ser_dc),
        .ready   (ser_ready),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .dc      (spi_dc)
    );

endmodule

// File: rtl/spi_stream_chk.sv
// Bus-rule checker for spi_frame_streamer, attached by bind below.
// Assumes: synchronous active-low reset; HALF is the minimum phase width.
module spi_stream_chk #(
    parameter int unsigned HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic spi_dc,
    input logic pix_ready
);
    logic       sclk_q;
    logic [7:0] run;

    // Measure how long SCLK has held its previous level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            run    <= 8'hFF;
        end else begin
            sclk_q <= spi_sclk;
            if (spi_sclk != sclk_q)
                run <= 8'd1;
            else if (run != 8'hFF)
                run <= run + 1'b1;
        end
    end

    // R1
    idle_clock_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R4
    dc_change_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_dc != $past(spi_dc)) |-> (!spi_sclk && !spi_cs_n));

    // R5
    mosi_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_mosi != $past(spi_mosi)) |-> !spi_sclk);

    // R6
    sclk_phase_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk != sclk_q) |-> (run >= 8'(HALF)));

    // R7
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> !spi_cs_n);

    // R3
    deselect_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (!spi_sclk && !$past(spi_sclk)));

endmodule

bind spi_frame_streamer spi_stream_chk #(.HALF(HALF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n),
    .spi_dc    (spi_dc),
    .pix_ready (pix_ready)
);

// File: tb/tb_spi_frame_streamer.sv
module tb_spi_frame_streamer;
    localparam int TW   = 4;
    localparam int TH   = 3;
    localparam int NPX  = TW * TH;
    localparam int NBY  = 11 + 2 * NPX;
    localparam int TFR  = 2000;

    typedef struct packed {
        logic [15:0] base;
        logic [15:0] step;
        logic [15:0] stall_len;
        logic [7:0]  stall_every;
    } vec_t;

    // One entry per frame: pixel pattern and source stall pattern
    localparam vec_t VECS [4] = '{
        '{16'hA55A, 16'h0101, 16'd0,    8'd0},
        '{16'hFFFF, 16'hFFFF, 16'd40,   8'd3},
        '{16'h0001, 16'h1357, 16'd2500, 8'd6},
        '{16'h8000, 16'h0003, 16'd1,    8'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pix_data = '0;
    logic        pix_valid = 1'b0;
    logic        pix_ready, spi_sclk, spi_mosi, spi_cs_n, spi_dc;

    int total = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_frame_streamer #(
        .CLK_HZ(50_000_000), .SCLK_MAX_HZ(20_000_000),
        .FRAME_CLKS(TFR), .H_PIXELS(TW), .V_PIXELS(TH)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Edge timing of chip select and SCLK phase widths, sampled mid-cycle
    int fall_t [8], rise_t [8];
    int nfall = 0, nrise = 0;
    logic prev_cs = 1'b1, prev_sck = 1'b0;
    int run = 0, min_hi = 999, max_hi = 0, min_lo = 999;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !spi_cs_n && nfall < 8) begin fall_t[nfall] = cyc; nfall++; end
            if (!prev_cs && spi_cs_n && nrise < 8) begin rise_t[nrise] = cyc; nrise++; end
            if (spi_sclk != prev_sck) begin
                if (prev_sck) begin
                    if (run < min_hi) min_hi = run;
                    if (run > max_hi) max_hi = run;
                end else if (run < min_lo) min_lo = run;
                run = 1;
            end else run++;
            prev_cs  = spi_cs_n;
            prev_sck = spi_sclk;
        end
    end

    // Decode the serial bus into bytes
    logic [7:0] bq [64];
    logic       dq [64];
    logic [7:0] cur = '0;
    int  bitn = 0, nbytes = 0, frames_seen = 0;
    logic byte_dc = 1'b0;
    bit  dc_glitch = 1'b0, cs_glitch = 1'b0;

    always @(posedge spi_sclk) begin
        if (bitn == 0) byte_dc = spi_dc;
        else if (spi_dc != byte_dc) dc_glitch = 1'b1;
        if (spi_cs_n) cs_glitch = 1'b1;
        cur = {cur[6:0], spi_mosi};
        bitn++;
        if (bitn == 8) begin
            if (nbytes < 64) begin bq[nbytes] = cur; dq[nbytes] = byte_dc; end
            nbytes++;
            bitn = 0;
        end
    end

    function automatic logic [7:0] exp_byte(input int f, input int k);
        logic [15:0] px;
        case (k)
            0:  return 8'h2A;
            3:  return 8'((TW - 1) >> 8);
            4:  return 8'(TW - 1);
            5:  return 8'h2B;
            8:  return 8'((TH - 1) >> 8);
            9:  return 8'(TH - 1);
            10: return 8'h2C;
            default: begin
                if (k < 11) return 8'h00;
                px = VECS[f].base + 16'((k - 11) / 2) * VECS[f].step;
                return (((k - 11) % 2) == 0) ? px[15:8] : px[7:0];
            end
        endcase
    endfunction

    // Check each completed frame against the expected byte stream
    always @(posedge spi_cs_n) begin
        if (nbytes > 0 && frames_seen < 4) begin
            int f, bad_hdr, bad_pix, bad_dc, first_k;
            f = frames_seen;
            bad_hdr = 0; bad_pix = 0; bad_dc = 0; first_k = -1;
            chk(nbytes == NBY && bitn == 0, "R3 frame byte count", nbytes, NBY);
            for (int k = 0; k < NBY && k < nbytes; k++) begin
                if (bq[k] != exp_byte(f, k)) begin
                    if (k < 11) bad_hdr++; else bad_pix++;
                    if (first_k < 0) first_k = k;
                end
                if (dq[k] != !(k == 0 || k == 5 || k == 10)) bad_dc++;
            end
            chk(bad_hdr == 0 && !cs_glitch, "R3 header bytes",
                (first_k >= 0) ? bq[first_k] : 0, (first_k >= 0) ? exp_byte(f, first_k) : 0);
            chk(bad_pix == 0, "R5 R7 R8 pixel bytes and order",
                (first_k >= 0) ? bq[first_k] : 0, (first_k >= 0) ? exp_byte(f, first_k) : 0);
            chk(bad_dc == 0 && !dc_glitch, "R4 dc per byte", bad_dc, 0);
            frames_seen++;
        end
        nbytes = 0; bitn = 0; dc_glitch = 1'b0; cs_glitch = 1'b0;
    end

    task automatic send_pix(input logic [15:0] v, input int stall);
        bit r;
        if (stall > 0) begin
            pix_valid = 1'b0;
            repeat (stall / 2) @(negedge clk);
            if (stall > 1000) begin
                chk(spi_sclk == 1'b0, "R8 sclk parked during stall", spi_sclk, 0);
                chk(spi_cs_n == 1'b0 && spi_dc == 1'b1, "R8 cs and dc held during stall",
                    {spi_cs_n, spi_dc}, 1);
            end
            repeat (stall - stall / 2) @(negedge clk);
        end
        pix_valid = 1'b1;
        pix_data  = v;
        forever begin
            #1 r = pix_ready;
            if (r) break;
            @(negedge clk);
        end
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs_n in reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1 sclk in reset", spi_sclk, 0);
        chk(pix_ready == 1'b0, "R1 pix_ready in reset", pix_ready, 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        chk(spi_cs_n == 1'b1 && pix_ready == 1'b0, "R1 idle before first tick",
            {spi_cs_n, pix_ready}, 2);
        // Table walk: pixel source for four frames
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < NPX; i++) begin
                int st;
                st = (VECS[f].stall_every != 0 &&
                      (i % VECS[f].stall_every) == VECS[f].stall_every - 1)
                     ? int'(VECS[f].stall_len) : 0;
                send_pix(VECS[f].base + 16'(i) * VECS[f].step, st);
            end
        end
        wait (frames_seen == 4 && nfall >= 5);
        @(negedge clk);
        chk(fall_t[1] - fall_t[0] == TFR, "R2 frame spacing 0-1", fall_t[1] - fall_t[0], TFR);
        chk(fall_t[2] - fall_t[1] == TFR, "R2 frame spacing 1-2", fall_t[2] - fall_t[1], TFR);
        chk(fall_t[3] - rise_t[2] == 1, "R9 pending frame gap", fall_t[3] - rise_t[2], 1);
        chk(fall_t[4] - rise_t[3] > 1, "R9 ticks collapsed", fall_t[4] - rise_t[3], 2);
        chk((fall_t[4] - fall_t[0]) % TFR == 0, "R2 restart on tick grid",
            (fall_t[4] - fall_t[0]) % TFR, 0);
        chk(min_hi == 2 && max_hi == 2, "R6 sclk high phase", min_hi, 2);
        chk(min_lo >= 2, "R6 sclk low phase", min_lo, 2);
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d frames", frames_seen, 4);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule